// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host read and write an internal byte-wide register space over a three-wire serial link: an active-low select, a serial clock and one bidirectional data line. The data line is split into an input, an output and an output enable at this boundary. All three pins are brought into the system clock domain through a synchronizer chain. Edges are then detected on the system clock, so the block runs on a single clock that must be much faster than the serial clock.

After reset the block is in pin-control mode. The first falling edge of select moves it into serial-control mode for good. At that moment it samples two default settings from the pin levels. The data-line level gives the output-standard default, and the clock-line level gives the number-format default. The format default covers only two's complement and offset binary; gray code is left to a later register write. Each transaction opens with a 16-bit instruction, sent most significant bit first. The instruction carries a read flag, a two-bit byte-count code and a 13-bit start address. Whole data bytes follow, and the address advances by one after each byte.

The controller has seven states. `ST_PIN` leaves to `ST_INSTR` on the first select fall. `ST_IDLE` leaves to `ST_INSTR` on any select fall. `ST_INSTR` goes to `ST_FETCH` (read) or `ST_DATA` (write) after the sixteenth bit. `ST_FETCH` always goes to `ST_DATA`. `ST_DATA` goes after eight bits to `ST_COMMIT` for a write, or to `ST_FETCH`/`ST_DONE` for a read. `ST_COMMIT` goes to `ST_DATA`, or to `ST_DONE` once the count is used up. Every state except `ST_PIN` and `ST_IDLE` returns to `ST_IDLE` on a select rise.

Top module: `spi3w_reg_slave`

## Requirements
- R1: After reset the block is in pin-control mode: `spi_ctl_mode`=0, `spi_sdio_oe`=0, and no register read or write strobe is raised.
- R2: The first select fall sets `spi_ctl_mode`=1 permanently. It latches `dflt_out_std` from the data-in level and `dflt_fmt_sel` from the clock level. Later select falls leave both unchanged.
- R3: The instruction is the first 16 bits after a select fall, sampled on clock rises, most significant bit first. Bit 15 is the read flag (1 = read), bits 14:13 are the count code, and bits 12:0 are the start address.
- R4: Count codes 0, 1 and 2 give exactly 1, 2 and 3 data bytes. After that, clock edges cause no register access until the next select fall.
- R5: Count code 3 keeps transferring bytes until select rises.
- R6: A write raises `reg_wr_en` for one system clock after all eight bits of a byte have arrived, with the byte (first bit in bit 7) on `reg_wdata`.
- R7: The first byte uses the instruction address. Each further byte uses the previous address plus one, wrapping modulo 2^13.
- R8: On a read, `reg_rd_en` pulses at each byte boundary. The fetched byte is then driven on `spi_sdio_o` with `spi_sdio_oe`=1, bit 7 first, each bit valid before the clock rise that samples it.
- R9: `spi_sdio_oe` falls after the last counted read byte, or when select rises.
- R10: A select rise in the middle of a byte discards the partial byte and returns to idle. The next transaction then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn_i | input | 1 | Serial select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_sdio_i | input | 1 | Data line, input side |
| spi_sdio_o | output | 1 | Data line, output side |
| spi_sdio_oe | output | 1 | Data line output enable |
| spi_ctl_mode | output | 1 | 1 once serial-control mode is entered |
| dflt_out_std | output | 1 | Latched output-standard default |
| dflt_fmt_sel | output | 1 | Latched number-format default |
| reg_addr | output | 13 | Register address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid in the cycle of `reg_rd_en` |

## Verification
The bench builds the block with its default two-stage synchronizer and a serial half period of eight system clocks. That leaves room for the fetch cycle between a byte boundary and the next sampled bit. With these values the bench can reach the address wrap from 0x1FFF to 0x0000 within one transfer. It also covers byte counts past the coded limit, an abort four bits into a byte, and a second select fall with opposite pin levels.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
    localparam int INSTR_BITS = 16;
    localparam int BYTE_BITS  = 8;
    localparam int ADDR_BITS  = 13;
    localparam int CNT_BITS   = 2;
    localparam int BITCNT_W   = $clog2(INSTR_BITS);

    typedef enum logic [2:0] {
        ST_PIN,
        ST_IDLE,
        ST_INSTR,
        ST_FETCH,
        ST_DATA,
        ST_COMMIT,
        ST_DONE
    } xfer_state_e;
endpackage

// File: rtl/spi3w_pin_sync.sv
module spi3w_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi3w_mode_entry.sv
module spi3w_mode_entry (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_fall,
    input  logic sdi_lvl,
    input  logic sck_lvl,
    output logic spi_mode,
    output logic dflt_std,
    output logic dflt_fmt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_mode <= 1'b0;
            dflt_std <= 1'b0;
            dflt_fmt <= 1'b0;
        end else if (!spi_mode && csn_fall) begin
            spi_mode <= 1'b1;
            dflt_std <= sdi_lvl;
            dflt_fmt <= sck_lvl;
        end
    end

    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> spi_mode);
    assert_dflt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_mode) |-> $stable({dflt_std, dflt_fmt}));
endmodule

// File: rtl/spi3w_xfer_fsm.sv
module spi3w_xfer_fsm
    import spi3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csn_fall,
    input  logic                 csn_rise,
    input  logic                 csn_lvl,
    input  logic                 sck_rise,
    input  logic                 sdi,
    input  logic                 spi_mode,
    input  logic [BYTE_BITS-1:0] reg_rdata,
    output logic [ADDR_BITS-1:0] reg_addr,
    output logic                 reg_wr_en,
    output logic [BYTE_BITS-1:0] reg_wdata,
    output logic                 reg_rd_en,
    output logic                 sdio_o,
    output logic                 sdio_oe
);
    xfer_state_e state_q, state_d;

    logic [BITCNT_W-1:0]   bit_cnt_q;
    logic [INSTR_BITS-2:0] instr_sh_q;
    logic [BYTE_BITS-1:0]  rx_sh_q, tx_sh_q;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [CNT_BITS-1:0]   left_q;
    logic                  rd_q, unl_q;
    logic                  last_byte, instr_end, byte_end;

    assign last_byte = !unl_q && (left_q == '0);
    assign instr_end = sck_rise && (bit_cnt_q == BITCNT_W'(INSTR_BITS-1));
    assign byte_end  = sck_rise && (bit_cnt_q == BITCNT_W'(BYTE_BITS-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PIN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PIN, ST_IDLE: if (csn_fall) state_d = ST_INSTR;
            ST_INSTR:  if (csn_rise) state_d = ST_IDLE;
                       else if (instr_end) state_d = instr_sh_q[INSTR_BITS-2] ? ST_FETCH : ST_DATA;
            ST_FETCH:  state_d = csn_rise ? ST_IDLE : ST_DATA;
            ST_DATA:   if (csn_rise) state_d = ST_IDLE;
                       else if (byte_end) state_d = !rd_q ? ST_COMMIT : (last_byte ? ST_DONE : ST_FETCH);
            ST_COMMIT: state_d = csn_rise ? ST_IDLE : (last_byte ? ST_DONE : ST_DATA);
            ST_DONE:   if (csn_rise) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            instr_sh_q <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            addr_q     <= '0;
            left_q     <= '0;
            rd_q       <= 1'b0;
            unl_q      <= 1'b0;
        end else begin
            if (csn_fall) bit_cnt_q <= '0;
            unique case (state_q)
                ST_INSTR: if (sck_rise) begin
                    instr_sh_q <= {instr_sh_q[INSTR_BITS-3:0], sdi};
                    bit_cnt_q  <= bit_cnt_q + 1'b1;
                    if (instr_end) begin
                        rd_q      <= instr_sh_q[INSTR_BITS-2];
                        left_q    <= instr_sh_q[ADDR_BITS+CNT_BITS-2:ADDR_BITS-1];
                        unl_q     <= &instr_sh_q[ADDR_BITS+CNT_BITS-2:ADDR_BITS-1];
                        addr_q    <= {instr_sh_q[ADDR_BITS-2:0], sdi};
                        bit_cnt_q <= '0;
                    end
                end
                ST_FETCH: tx_sh_q <= reg_rdata;
                ST_DATA: if (sck_rise) begin
                    rx_sh_q   <= {rx_sh_q[BYTE_BITS-2:0], sdi};
                    tx_sh_q   <= {tx_sh_q[BYTE_BITS-2:0], 1'b0};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (byte_end) begin
                        bit_cnt_q <= '0;
                        if (rd_q) begin
                            addr_q <= addr_q + 1'b1;
                            if (!last_byte && !unl_q) left_q <= left_q - 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    addr_q <= addr_q + 1'b1;
                    if (!last_byte && !unl_q) left_q <= left_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        reg_addr  = addr_q;
        reg_wdata = rx_sh_q;
        reg_wr_en = (state_q == ST_COMMIT);
        reg_rd_en = (state_q == ST_FETCH);
        sdio_o    = tx_sh_q[BYTE_BITS-1];
        sdio_oe   = (state_q == ST_DATA) && rd_q;
    end

    assert_no_access_pin_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_mode |-> !(reg_wr_en || reg_rd_en));
    assert_wr_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    assert_wr_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_addr == $past(reg_addr) + 1'b1));
    assert_rd_drives_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !csn_rise) |=> sdio_oe);
    assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_lvl && $past(csn_lvl)) |-> !sdio_oe);
endmodule

// File: rtl/spi3w_reg_slave.sv
module spi3w_reg_slave
    import spi3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_csn_i,
    input  logic                 spi_sclk_i,
    input  logic                 spi_sdio_i,
    output logic                 spi_sdio_o,
    output logic                 spi_sdio_oe,
    output logic                 spi_ctl_mode,
    output logic                 dflt_out_std,
    output logic                 dflt_fmt_sel,
    output logic [ADDR_BITS-1:0] reg_addr,
    output logic                 reg_wr_en,
    output logic [BYTE_BITS-1:0] reg_wdata,
    output logic                 reg_rd_en,
    input  logic [BYTE_BITS-1:0] reg_rdata
);
    logic [2:0] pin_lvl;
    logic       csn_lvl, sck_lvl, sdi_lvl;
    logic       csn_d, sck_d;
    logic       csn_fall, csn_rise, sck_rise;

    spi3w_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i({spi_csn_i, spi_sclk_i, spi_sdio_i}),
        .lvl_o(pin_lvl)
    );

    assign {csn_lvl, sck_lvl, sdi_lvl} = pin_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            csn_d <= csn_lvl;
            sck_d <= sck_lvl;
        end
    end

    assign csn_fall = csn_d && !csn_lvl;
    assign csn_rise = !csn_d && csn_lvl;
    assign sck_rise = !sck_d && sck_lvl && !csn_lvl;

    spi3w_mode_entry u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_fall(csn_fall),
        .sdi_lvl (sdi_lvl),
        .sck_lvl (sck_lvl),
        .spi_mode(spi_ctl_mode),
        .dflt_std(dflt_out_std),
        .dflt_fmt(dflt_fmt_sel)
    );

    spi3w_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_fall (csn_fall),
        .csn_rise (csn_rise),
        .csn_lvl  (csn_lvl),
        .sck_rise (sck_rise),
        .sdi      (sdi_lvl),
        .spi_mode (spi_ctl_mode),
        .reg_rdata(reg_rdata),
        .reg_addr (reg_addr),
        .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata),
        .reg_rd_en(reg_rd_en),
        .sdio_o   (spi_sdio_o),
        .sdio_oe  (spi_sdio_oe)
    );
endmodule

// File: tb/spi3w_reg_slave_tb.sv
module spi3w_reg_slave_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, sdio = 1'b0;
    logic        sdo, sdo_oe, mode, dstd, dfmt, wr_en, rd_en;
    logic [12:0] addr;
    logic [7:0]  wdata, rdata;

    int checks = 0;
    int errors = 0;
    int wr_n = 0;
    logic [12:0] wr_a [64];
    logic [7:0]  wr_d [64];

    always #2 clk = ~clk;

    function automatic logic [7:0] mdl(input logic [12:0] a);
        return {a[4:0], a[7:5]} ^ 8'h3C ^ {3'b000, a[12:8]};
    endfunction

    assign rdata = mdl(addr);

    spi3w_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n),
        .spi_csn_i(csn), .spi_sclk_i(sclk), .spi_sdio_i(sdio),
        .spi_sdio_o(sdo), .spi_sdio_oe(sdo_oe),
        .spi_ctl_mode(mode), .dflt_out_std(dstd), .dflt_fmt_sel(dfmt),
        .reg_addr(addr), .reg_wr_en(wr_en), .reg_wdata(wdata),
        .reg_rd_en(rd_en), .reg_rdata(rdata)
    );

    always @(posedge clk) begin
        if (rst_n && wr_en && wr_n < 64) begin
            wr_a[wr_n] <= addr;
            wr_d[wr_n] <= wdata;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic spi_start(input logic d_lvl, input logic c_lvl);
        @(negedge clk);
        sdio = d_lvl; sclk = c_lvl;
        repeat (4) @(negedge clk);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_end();
        @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic rb, output logic oe);
        @(negedge clk);
        sclk = 1'b0; sdio = b;
        repeat (HALF) @(negedge clk);
        rb = sdo; oe = sdo_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_instr(input logic rd, input logic [1:0] code, input logic [12:0] a);
        logic [15:0] w;
        logic rb, oe;
        w = {rd, code, a};
        for (int i = 15; i >= 0; i--) spi_bit(w[i], rb, oe);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx, output int oe_cnt);
        logic rb, oe;
        rx = '0; oe_cnt = 0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(tx[i], rb, oe);
            rx[i] = rb;
            oe_cnt += int'(oe);
        end
    endtask

    task automatic t_reset();
        chk("R1", "mode after reset", int'(mode), 0);
        chk("R1", "oe after reset", int'(sdo_oe), 0);
        chk("R1", "writes after reset", wr_n, 0);
    endtask

    task automatic t_mode_entry();
        spi_start(1'b1, 1'b1);
        repeat (4) @(negedge clk);
        chk("R2", "mode entered", int'(mode), 1);
        chk("R2", "std default from data pin", int'(dstd), 1);
        chk("R2", "fmt default from clock pin", int'(dfmt), 1);
        spi_end();
        spi_start(1'b0, 1'b0);
        spi_end();
        chk("R2", "std held on later fall", int'(dstd), 1);
        chk("R2", "fmt held on later fall", int'(dfmt), 1);
        chk("R2", "mode held", int'(mode), 1);
    endtask

    task automatic t_write_one();
        int base = wr_n;
        logic [7:0] rx; int oc;
        spi_start(1'b0, 1'b0);
        send_instr(1'b0, 2'b00, 13'h0123);
        xfer_byte(8'h5A, rx, oc);
        xfer_byte(8'hFF, rx, oc);
        xfer_byte(8'h81, rx, oc);
        spi_end();
        chk("R4", "code 0 write count", wr_n - base, 1);
        chk("R3", "write address", int'(wr_a[base]), 'h123);
        chk("R6", "write data", int'(wr_d[base]), 'h5A);
    endtask

    task automatic t_write_three_wrap();
        int base = wr_n;
        logic [7:0] rx; int oc;
        spi_start(1'b0, 1'b0);
        send_instr(1'b0, 2'b10, 13'h1FFE);
        xfer_byte(8'h11, rx, oc);
        xfer_byte(8'h22, rx, oc);
        xfer_byte(8'h33, rx, oc);
        xfer_byte(8'h44, rx, oc);
        spi_end();
        chk("R4", "code 2 write count", wr_n - base, 3);
        chk("R7", "addr byte 2", int'(wr_a[base+1]), 'h1FFF);
        chk("R7", "addr wrap byte 3", int'(wr_a[base+2]), 'h0000);
        chk("R6", "data byte 3", int'(wr_d[base+2]), 'h33);
    endtask

    task automatic t_write_stream();
        int base = wr_n;
        logic [7:0] rx; int oc;
        spi_start(1'b0, 1'b0);
        send_instr(1'b0, 2'b11, 13'h0040);
        for (int k = 0; k < 5; k++) xfer_byte(8'(8'hA0 + k), rx, oc);
        spi_end();
        chk("R5", "code 3 write count", wr_n - base, 5);
        chk("R7", "addr byte 5", int'(wr_a[base+4]), 'h44);
        chk("R5", "data byte 5", int'(wr_d[base+4]), 'hA4);
    endtask

    task automatic t_read_two();
        int base = wr_n;
        logic [7:0] rx; int oc;
        spi_start(1'b0, 1'b0);
        send_instr(1'b1, 2'b01, 13'h0010);
        xfer_byte(8'h00, rx, oc);
        chk("R8", "read byte 1", int'(rx), int'(mdl(13'h0010)));
        chk("R8", "oe bits byte 1", oc, 8);
        xfer_byte(8'h00, rx, oc);
        chk("R8", "read byte 2", int'(rx), int'(mdl(13'h0011)));
        xfer_byte(8'h00, rx, oc);
        chk("R9", "oe after counted bytes", oc, 0);
        spi_end();
        chk("R8", "read causes no write", wr_n - base, 0);
    endtask

    task automatic t_read_stream();
        logic [7:0] rx; int oc;
        spi_start(1'b0, 1'b0);
        send_instr(1'b1, 2'b11, 13'h1FFF);
        xfer_byte(8'h00, rx, oc);
        chk("R8", "stream read 1", int'(rx), int'(mdl(13'h1FFF)));
        xfer_byte(8'h00, rx, oc);
        chk("R7", "stream read wrap", int'(rx), int'(mdl(13'h0000)));
        xfer_byte(8'h00, rx, oc);
        chk("R5", "stream read 3", int'(rx), int'(mdl(13'h0001)));
        chk("R5", "oe still on", int'(sdo_oe), 1);
        spi_end();
        chk("R9", "oe off after deselect", int'(sdo_oe), 0);
    endtask

    task automatic t_abort();
        int base = wr_n;
        logic [7:0] rx; int oc;
        logic rb, oe;
        spi_start(1'b0, 1'b0);
        send_instr(1'b0, 2'b11, 13'h0200);
        xfer_byte(8'hC3, rx, oc);
        spi_bit(1'b1, rb, oe); spi_bit(1'b0, rb, oe);
        spi_bit(1'b1, rb, oe); spi_bit(1'b0, rb, oe);
        spi_end();
        chk("R10", "partial byte dropped", wr_n - base, 1);
        chk("R10", "full byte kept", int'(wr_d[base]), 'hC3);
        spi_start(1'b0, 1'b0);
        send_instr(1'b0, 2'b00, 13'h0300);
        xfer_byte(8'h7E, rx, oc);
        spi_end();
        chk("R10", "next write count", wr_n - base, 2);
        chk("R10", "next write addr", int'(wr_a[base+1]), 'h300);
        chk("R10", "next write data", int'(wr_d[base+1]), 'h7E);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_mode_entry();
        t_write_one();
        t_write_three_wrap();
        t_write_stream();
        t_read_two();
        t_read_stream();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule